// File: doc/BRIEF.md
# ECC Error Capture and Interrupt Register Block

This block sits next to an ECC-protected memory with 64-bit words and holds the error state that software sees. The ECC decoder gives it one-cycle reports of correctable and uncorrectable errors. Each report carries the word offset inside the memory and the 64-bit data word involved. Each error class has its own status bit and its own capture registers. The capture registers keep the first failure of that class until software acknowledges it.

A level interrupt is raised while any status bit is set and its mask bit is clear. Software controls the mask through two registers. Writing ones to the enable register clears mask bits. Writing ones to the disable register sets them. Software acknowledges an error by writing a one to its status bit. An ECC-enable control bit completes the register map. Access is through a plain 32-bit register port with separate write and read strobes, and read data is registered.

Top module: `ecc_err_regs`

## Requirements
- R1: After reset the status register (0x04) reads 0, the mask register (0x08) reads 0x0000_00C0, irq is low, all capture registers read 0, and the ECC control register (0x14) reads 1.
- R2: A correctable report (ce_evt high for one cycle) sets bit 6 of the status register. An uncorrectable report (ue_evt) sets bit 7. All other status bits read 0.
- R3: A write to 0x04 clears each of bits 6 and 7 where the write data has a 1, and leaves the bits where it has a 0 unchanged.
- R4: If a report and a clearing write to the same status bit fall in the same cycle, the bit ends up set.
- R5: A write to 0x0C clears mask bits 6 and 7 where the data has a 1. A write to 0x10 sets them where the data has a 1. Registers 0x0C and 0x10 read 0.
- R6: irq is high exactly when (status & ~mask) has bit 6 or bit 7 set. It follows status and mask in the same cycle in which those registers change.
- R7: When a correctable report is taken, the word offset is captured and reads zero-extended at 0x1C. Data bits 31:0 read at 0x20 and bits 63:32 read at 0x24.
- R8: When an uncorrectable report is taken, the offset reads at 0x34, data bits 31:0 at 0x38, and data bits 63:32 at 0x3C.
- R9: A capture loads only while the status bit of its class is clear. Later reports of that class do not overwrite it until the bit has been cleared.
- R10: Bit 0 of 0x14 can be written and read back, drives the ecc_en output, and the other bits of 0x14 read 0.
- R11: Offsets that are not mapped read 0. Read data appears on reg_rdata in the cycle after the reg_rd strobe and holds until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| ce_evt | input | 1 | Correctable error report, one cycle |
| ce_addr | input | ADDR_W | Word offset of the correctable error |
| ce_data | input | DATA_W | Data word of the correctable error |
| ue_evt | input | 1 | Uncorrectable error report, one cycle |
| ue_addr | input | ADDR_W | Word offset of the uncorrectable error |
| ue_data | input | DATA_W | Data word of the uncorrectable error |
| ecc_en | output | 1 | ECC enable control bit |
| irq | output | 1 | Level interrupt |

## Verification
Two functions can act on the same status bit in one cycle: an error report from the decoder and software's write-one-to-clear acknowledge. The bench drives ce_evt or ue_evt in the same cycle as a write of ones to 0x04. It does this with the bit clear beforehand and again with the bit already set. It then reads back the status bit, which must be set, and the capture registers. When the bit was already set, the captures must still hold the earlier failure. A sweep over all mask and status combinations also checks that irq tracks status and mask in the same cycle.

// File: rtl/ecc_err_pkg.sv
package ecc_err_pkg;
  localparam int NUM_CLS = 2;
  localparam int CLS_CE  = 0;
  localparam int CLS_UE  = 1;
  // status/mask bit position of each class
  localparam int CE_BIT  = 6;
  localparam int UE_BIT  = 7;

  localparam logic [7:0] OFS_STAT   = 8'h04;
  localparam logic [7:0] OFS_MASK   = 8'h08;
  localparam logic [7:0] OFS_ENA    = 8'h0C;
  localparam logic [7:0] OFS_DIS    = 8'h10;
  localparam logic [7:0] OFS_CTRL   = 8'h14;
  localparam logic [7:0] OFS_CE_ADR = 8'h1C;
  localparam logic [7:0] OFS_CE_DLO = 8'h20;
  localparam logic [7:0] OFS_CE_DHI = 8'h24;
  localparam logic [7:0] OFS_UE_ADR = 8'h34;
  localparam logic [7:0] OFS_UE_DLO = 8'h38;
  localparam logic [7:0] OFS_UE_DHI = 8'h3C;

  function automatic logic [31:0] cls_to_word(input logic [NUM_CLS-1:0] v);
    logic [31:0] w;
    w = '0;
    w[CE_BIT] = v[CLS_CE];
    w[UE_BIT] = v[CLS_UE];
    return w;
  endfunction

  function automatic logic [NUM_CLS-1:0] word_to_cls(input logic [31:0] w);
    logic [NUM_CLS-1:0] v;
    v[CLS_CE] = w[CE_BIT];
    v[CLS_UE] = w[UE_BIT];
    return v;
  endfunction
endpackage

// File: rtl/ecc_capture.sv
module ecc_capture #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  output logic [ADDR_W-1:0] cap_addr,
  output logic [DATA_W-1:0] cap_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cap_addr <= '0;
      cap_data <= '0;
    end else if (load) begin
      cap_addr <= in_addr;
      cap_data <= in_data;
    end
  end
endmodule

// File: rtl/ecc_irq_ctrl.sv
module ecc_irq_ctrl #(
  parameter int NCLS = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NCLS-1:0] evt,
  input  logic [NCLS-1:0] clr,
  input  logic [NCLS-1:0] unmask,
  input  logic [NCLS-1:0] domask,
  output logic [NCLS-1:0] stat_q,
  output logic [NCLS-1:0] mask_q,
  output logic            irq
);
  logic [NCLS-1:0] stat_d, mask_d;

  always_comb begin
    // set has priority over clear
    stat_d = (stat_q & ~clr) | evt;
    mask_d = (mask_q & ~unmask) | domask;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      mask_q <= '1;
      irq    <= 1'b0;
    end else begin
      stat_q <= stat_d;
      mask_q <= mask_d;
      irq    <= |(stat_d & ~mask_d);
    end
  end
endmodule

// File: rtl/ecc_err_regs.sv
module ecc_err_regs
  import ecc_err_pkg::*;
#(
  parameter int   ADDR_W     = 18,
  parameter int   DATA_W     = 64,
  parameter logic ECC_EN_RST = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [7:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              ce_evt,
  input  logic [ADDR_W-1:0] ce_addr,
  input  logic [DATA_W-1:0] ce_data,
  input  logic              ue_evt,
  input  logic [ADDR_W-1:0] ue_addr,
  input  logic [DATA_W-1:0] ue_data,
  output logic              ecc_en,
  output logic              irq
);
  localparam int WIDE_W = (DATA_W > 64) ? DATA_W : 64;

  logic [NUM_CLS-1:0]             evt;
  logic [NUM_CLS-1:0]             stat_q, mask_q;
  logic [NUM_CLS-1:0]             w_clr, w_ena, w_dis;
  logic [NUM_CLS-1:0][ADDR_W-1:0] ev_addr, cap_addr;
  logic [NUM_CLS-1:0][DATA_W-1:0] ev_data, cap_data;
  logic [NUM_CLS-1:0][WIDE_W-1:0] cap_wide;
  logic [NUM_CLS-1:0]             wcls;
  logic [31:0]                    rd_mux;

  assign evt     = {ue_evt, ce_evt};
  assign ev_addr = {ue_addr, ce_addr};
  assign ev_data = {ue_data, ce_data};

  assign wcls  = word_to_cls(reg_wdata);
  assign w_clr = (reg_wr && reg_addr == OFS_STAT) ? wcls : '0;
  assign w_ena = (reg_wr && reg_addr == OFS_ENA)  ? wcls : '0;
  assign w_dis = (reg_wr && reg_addr == OFS_DIS)  ? wcls : '0;

  ecc_irq_ctrl #(.NCLS(NUM_CLS)) u_irq (
    .clk    (clk),
    .rst    (rst),
    .evt    (evt),
    .clr    (w_clr),
    .unmask (w_ena),
    .domask (w_dis),
    .stat_q (stat_q),
    .mask_q (mask_q),
    .irq    (irq)
  );

  for (genvar k = 0; k < NUM_CLS; k++) begin : g_cap
    ecc_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
      .clk      (clk),
      .rst      (rst),
      .load     (evt[k] && !stat_q[k]),
      .in_addr  (ev_addr[k]),
      .in_data  (ev_data[k]),
      .cap_addr (cap_addr[k]),
      .cap_data (cap_data[k])
    );
    assign cap_wide[k] = WIDE_W'(cap_data[k]);
  end

  always_ff @(posedge clk) begin
    if (rst) ecc_en <= ECC_EN_RST;
    else if (reg_wr && reg_addr == OFS_CTRL) ecc_en <= reg_wdata[0];
  end

  always_comb begin
    unique case (reg_addr)
      OFS_STAT:   rd_mux = cls_to_word(stat_q);
      OFS_MASK:   rd_mux = cls_to_word(mask_q);
      OFS_CTRL:   rd_mux = {31'b0, ecc_en};
      OFS_CE_ADR: rd_mux = 32'(cap_addr[CLS_CE]);
      OFS_CE_DLO: rd_mux = cap_wide[CLS_CE][31:0];
      OFS_CE_DHI: rd_mux = cap_wide[CLS_CE][63:32];
      OFS_UE_ADR: rd_mux = 32'(cap_addr[CLS_UE]);
      OFS_UE_DLO: rd_mux = cap_wide[CLS_UE][31:0];
      OFS_UE_DHI: rd_mux = cap_wide[CLS_UE][63:32];
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/ecc_err_chk.sv
module ecc_err_chk #(
  parameter int ADDR_W = 18
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   reg_wr,
  input logic [7:0]             reg_addr,
  input logic [31:0]            reg_wdata,
  input logic                   ce_evt,
  input logic                   ue_evt,
  input logic                   irq,
  input logic [1:0]             stat_q,
  input logic [1:0]             mask_q,
  input logic [1:0][ADDR_W-1:0] cap_addr
);
  // R6
  irq_level_chk: assert property (@(posedge clk) disable iff (rst)
    irq == |(stat_q & ~mask_q));
  // R4
  ce_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    ce_evt |=> stat_q[0]);
  // R4
  ue_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    ue_evt |=> stat_q[1]);
  // R3
  ce_w1c_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == 8'h04 && reg_wdata[6] && !ce_evt) |=> !stat_q[0]);
  // R9
  ce_hold_chk: assert property (@(posedge clk) disable iff (rst)
    stat_q[0] |=> $stable(cap_addr[0]));
  // R9
  ue_hold_chk: assert property (@(posedge clk) disable iff (rst)
    stat_q[1] |=> $stable(cap_addr[1]));
  // R5
  ue_unmask_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == 8'h0C && reg_wdata[7]) |=> !mask_q[1]);
  // R5
  ce_domask_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == 8'h10 && reg_wdata[6]) |=> mask_q[0]);
endmodule

bind ecc_err_regs ecc_err_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .ce_evt    (ce_evt),
  .ue_evt    (ue_evt),
  .irq       (irq),
  .stat_q    (stat_q),
  .mask_q    (mask_q),
  .cap_addr  (cap_addr)
);

// File: tb/sim_ecc_err_regs.sv
module sim_ecc_err_regs;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 18;
  localparam int DATA_W = 64;

  logic              clk = 0;
  logic              rst = 1;
  logic              reg_wr = 0, reg_rd = 0;
  logic [7:0]        reg_addr = 0;
  logic [31:0]       reg_wdata = 0;
  logic [31:0]       reg_rdata;
  logic              ce_evt = 0, ue_evt = 0;
  logic [ADDR_W-1:0] ce_addr = 0, ue_addr = 0;
  logic [DATA_W-1:0] ce_data = 0, ue_data = 0;
  logic              ecc_en, irq;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // bench model of captures: index 0 correctable, 1 uncorrectable
  logic [ADDR_W-1:0] m_addr [2];
  logic [DATA_W-1:0] m_data [2];
  logic [1:0]        m_stat, m_mask;
  logic              m_en;

  always #(CLK_P/2) clk = ~clk;

  ecc_err_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ce_evt(ce_evt), .ce_addr(ce_addr), .ce_data(ce_data),
    .ue_evt(ue_evt), .ue_addr(ue_addr), .ue_data(ue_data),
    .ecc_en(ecc_en), .irq(irq));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1; reg_addr = a;
    @(negedge clk);
    reg_rd = 0;
    d = reg_rdata;
  endtask

  // pulse reports; optional clearing write to status in the same cycle
  task automatic fire(input logic c, input logic u, input logic [ADDR_W-1:0] a,
                      input logic [DATA_W-1:0] d, input logic [31:0] clrw);
    @(negedge clk);
    ce_evt = c; ue_evt = u;
    ce_addr = a; ue_addr = a ^ 18'h2AAAA;
    ce_data = d; ue_data = ~d;
    if (clrw != 0) begin reg_wr = 1; reg_addr = 8'h04; reg_wdata = clrw; end
    @(negedge clk);
    ce_evt = 0; ue_evt = 0; reg_wr = 0;
    for (int k = 0; k < 2; k++) begin
      logic ev;
      ev = (k == 0) ? c : u;
      if (ev && !m_stat[k]) begin
        m_addr[k] = (k == 0) ? a : a ^ 18'h2AAAA;
        m_data[k] = (k == 0) ? d : ~d;
      end
    end
    m_stat = (m_stat & ~{clrw[7], clrw[6]}) | {u, c};
  endtask

  function automatic logic [31:0] exp_reg(input logic [7:0] a);
    case (a)
      8'h04: return {24'b0, m_stat, 6'b0};
      8'h08: return {24'b0, m_mask, 6'b0};
      8'h14: return {31'b0, m_en};
      8'h1C: return 32'(m_addr[0]);
      8'h20: return m_data[0][31:0];
      8'h24: return m_data[0][63:32];
      8'h34: return 32'(m_addr[1]);
      8'h38: return m_data[1][31:0];
      8'h3C: return m_data[1][63:32];
      default: return 32'h0;
    endcase
  endfunction

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    m_stat = 0; m_mask = 2'b11; m_en = 1;
    m_addr[0] = 0; m_addr[1] = 0; m_data[0] = 0; m_data[1] = 0;
    repeat (3) @(negedge clk);
    rst = 0;

    // R1 reset state, and R11 sweep of every offset
    check("R1 irq", {31'b0, irq}, 0);
    check("R1 ecc_en", {31'b0, ecc_en}, 1);
    for (int a = 0; a < 8'h80; a += 4) begin
      rd(8'(a), v);
      check($sformatf("R1/R11 reg %h", a), v, exp_reg(8'(a)));
    end

    // R11 read data holds without strobe
    rd(8'h08, v);
    @(negedge clk); reg_addr = 8'h04;
    @(negedge clk);
    check("R11 hold", reg_rdata, 32'hC0);

    // R10 control bit
    wr(8'h14, 32'hFFFF_FFFE); m_en = 0;
    rd(8'h14, v); check("R10 ctrl clr", v, 0);
    check("R10 ecc_en low", {31'b0, ecc_en}, 0);
    wr(8'h14, 32'h0000_0001); m_en = 1;
    rd(8'h14, v); check("R10 ctrl set", v, 1);

    // R2 R5 R6 sweep over all mask and event combinations
    for (int m = 0; m < 4; m++) begin
      for (int s = 0; s < 4; s++) begin
        wr(8'h04, 32'hC0); m_stat = 0;
        wr(8'h10, 32'hC0);
        wr(8'h0C, 32'(((~m) & 3) << 6)); m_mask = 2'(m);
        fire(s[0], s[1], 18'(s * 4 + m * 16 + 3), {32'hC0DE_0000 | 32'(s), 32'hBEEF_0000 | 32'(m)}, 0);
        check($sformatf("R6 irq m%0d s%0d", m, s), {31'b0, irq}, {31'b0, |(2'(s) & ~2'(m))});
        rd(8'h04, v); check("R2 status", v, 32'(s << 6));
        rd(8'h08, v); check("R5 mask", v, 32'(m << 6));
        for (int a = 8'h1C; a < 8'h40; a += 4) begin
          rd(8'(a), v); check($sformatf("R7/R8 cap %h", a), v, exp_reg(8'(a)));
        end
      end
    end
    rd(8'h0C, v); check("R5 ena reads 0", v, 0);
    rd(8'h10, v); check("R5 dis reads 0", v, 0);

    // R3 write-one-to-clear, zeros have no effect
    wr(8'h0C, 32'hC0); m_mask = 0;
    fire(1, 1, 18'h00111, 64'h1111_2222_3333_4444, 0);
    wr(8'h04, 32'hFFFF_FF3F);
    rd(8'h04, v); check("R3 zero bits ignored", v, 32'hC0);
    wr(8'h04, 32'h40); m_stat[0] = 0;
    rd(8'h04, v); check("R3 clear bit6", v, 32'h80);
    check("R6 irq ue only", {31'b0, irq}, 1);
    wr(8'h04, 32'h80); m_stat[1] = 0;
    rd(8'h04, v); check("R3 clear bit7", v, 0);
    check("R6 irq low", {31'b0, irq}, 0);

    // R9 first failure kept
    fire(1, 1, 18'h0ABCD, 64'hAAAA_BBBB_CCCC_DDDD, 0);
    fire(1, 1, 18'h01234, 64'h0101_0202_0303_0404, 0);
    for (int a = 8'h1C; a < 8'h40; a += 4) begin
      rd(8'(a), v); check($sformatf("R9 kept %h", a), v, exp_reg(8'(a)));
    end
    rd(8'h1C, v); check("R9 ce addr first", v, 32'h0ABCD);

    // R4 set wins while bit already set: capture not reloaded
    fire(1, 1, 18'h03333, 64'h9999_8888_7777_6666, 32'hC0);
    rd(8'h04, v); check("R4 set wins (set)", v, 32'hC0);
    rd(8'h20, v); check("R4/R9 no reload", v, 32'hCCCC_DDDD);

    // R4 set wins from clear state: capture loads
    wr(8'h04, 32'hC0); m_stat = 0;
    fire(1, 0, 18'h03FFFF, 64'hFEDC_BA98_7654_3210, 32'h40);
    rd(8'h04, v); check("R4 set wins (clear)", v, 32'h40);
    rd(8'h1C, v); check("R7 addr full width", v, 32'h3FFFF);
    rd(8'h24, v); check("R7 data hi", v, 32'hFEDC_BA98);
    check("R6 irq after race", {31'b0, irq}, 1);

    // R8 uncorrectable after clear loads new capture
    fire(0, 1, 18'h00005, 64'h0000_0001_8000_0000, 0);
    rd(8'h34, v); check("R8 ue addr", v, 32'h2AAAF);
    rd(8'h38, v); check("R8 ue lo", v, 32'h7FFF_FFFF);
    rd(8'h3C, v); check("R8 ue hi", v, 32'hFFFF_FFFE);

    finish_run();
  end
endmodule